// File: doc/BRIEF.md
# Display RAM write address generator

This block owns the write pointers for a one-bit-per-pixel display memory of 65 rows by 128 columns. The memory is organised as nine banks, each holding one byte per column: banks 0 to 7 cover eight pixel rows each, and the last bank carries a single icon row. A column pointer (X, 0..127) and a bank pointer (Y, 0..8) select the byte that the next incoming data byte writes.

On each data-byte strobe the block issues one registered RAM write. That write carries the bank, the physical column, the byte with its bits placed in the chosen vertical order, and a per-bit write mask. In the same cycle it advances the pointers. The advance is row-first (X then Y) or bank-first (Y then X), and the bank count is not a power of two. A mirror setting reverses the physical column without changing the direction in which the pointer counts. Load strobes from the command decoder set either pointer directly.

Top module: `dram_wr_addr_gen`

## Requirements
- R1: While reset is asserted and after its release, ptr_x=0, ptr_y=0 and ram_we=0.
- R2: With cfg_vert=0, each data write adds one to ptr_x. A write at ptr_x=127 sets ptr_x to 0 and adds one to ptr_y.
- R3: With cfg_vert=1, each data write adds one to ptr_y. A write at ptr_y=8 sets ptr_y to 0 and adds one to ptr_x.
- R4: A write at (X,Y)=(127,8) moves the pointers to (0,0) in both orders.
- R5: A wr_stb in cycle n gives ram_we=1 in cycle n+1, with ram_bank equal to the ptr_y held before the update. ram_we is 0 in any cycle that follows a cycle without wr_stb.
- R6: ram_col equals ptr_x when cfg_mirror=0 and 127-ptr_x when cfg_mirror=1. The pointer sequence is the same for both settings.
- R7: Bit k of ram_data lands on the pixel row 8*bank+k, so bit 0 is the top row. With cfg_lsb_top=0 the MSB goes on top: ram_data[k]=wr_data[7-k]. With cfg_lsb_top=1, ram_data=wr_data.
- R8: ram_mask is 8'hFF for banks 0..7. For bank 8 it is 8'h01, so only the icon-row bit is written and the other bits of the byte are ignored.
- R9: ld_x sets ptr_x to ld_x_val. ld_y sets ptr_y to ld_y_val, and any value above 8 is clamped to 8. A load takes priority over the advance from a write in the same cycle, and that write still uses the old pointers.
- R10: Without a write or a load, the pointers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_vert | input | 1 | 1 = bank-first advance, 0 = column-first |
| cfg_mirror | input | 1 | 1 = physical column is 127-X |
| cfg_lsb_top | input | 1 | 1 = LSB on the top row of the bank |
| wr_stb | input | 1 | Data byte write strobe |
| wr_data | input | 8 | Data byte |
| ld_x | input | 1 | Load strobe for the column pointer |
| ld_x_val | input | 7 | Column load value |
| ld_y | input | 1 | Load strobe for the bank pointer |
| ld_y_val | input | 4 | Bank load value (clamped to 8) |
| ram_we | output | 1 | Registered RAM write enable |
| ram_bank | output | 4 | RAM bank address |
| ram_col | output | 7 | Physical RAM column |
| ram_data | output | 8 | Byte with its bits in row order |
| ram_mask | output | 8 | Per-bit write mask |
| ptr_x | output | 7 | Current column pointer |
| ptr_y | output | 4 | Current bank pointer |

## Verification
The bench builds the block with its default parameters: 128 columns, 9 banks and 8-bit bytes. With these sizes, a full sweep of 1152 writes in each order is short enough to run, so every column wrap, every bank wrap and the final (127,8)→(0,0) corner are reached in both orders. Randomised mixes of loads, out-of-range bank loads, mirror and bit-order changes then run against a bench model of the pointer pair.

// File: rtl/wag_pkg.sv
package wag_pkg;
  typedef enum logic {
    ORDER_COL_FIRST  = 1'b0,
    ORDER_BANK_FIRST = 1'b1
  } walk_order_e;
endpackage

// File: rtl/wag_ptr.sv
module wag_ptr #(
  parameter int NCOL  = 128,
  parameter int NBANK = 9,
  parameter int XW    = $clog2(NCOL),
  parameter int YW    = $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  wag_pkg::walk_order_e order,
  input  logic          ldx,
  input  logic [XW-1:0] ldx_val,
  input  logic          ldy,
  input  logic [YW-1:0] ldy_val,
  output logic [XW-1:0] x_q,
  output logic [YW-1:0] y_q
);
  import wag_pkg::*;

  localparam logic [XW-1:0] XMAX = XW'(NCOL - 1);
  localparam logic [YW-1:0] YMAX = YW'(NBANK - 1);

  logic [XW-1:0] x_d;
  logic [YW-1:0] y_d;
  logic          en;

  // next-state logic: the walk first, then loads override it
  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (adv) begin
      if (order == ORDER_COL_FIRST) begin
        if (x_q == XMAX) begin
          x_d = '0;
          y_d = (y_q == YMAX) ? '0 : y_q + 1'b1;
        end else begin
          x_d = x_q + 1'b1;
        end
      end else begin
        if (y_q == YMAX) begin
          y_d = '0;
          x_d = (x_q == XMAX) ? '0 : x_q + 1'b1;
        end else begin
          y_d = y_q + 1'b1;
        end
      end
    end
    if (ldx) x_d = ldx_val;
    if (ldy) y_d = (ldy_val > YMAX) ? YMAX : ldy_val;
  end

  assign en = adv | ldx | ldy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (en) begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end
endmodule

// File: rtl/wag_map.sv
module wag_map #(
  parameter int NCOL  = 128,
  parameter int NBANK = 9,
  parameter int DW    = 8,
  parameter int XW    = $clog2(NCOL),
  parameter int YW    = $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  input  logic          mirror,
  input  logic          lsb_top,
  input  logic [DW-1:0] din,
  output logic          we_q,
  output logic [YW-1:0] bank_q,
  output logic [XW-1:0] col_q,
  output logic [DW-1:0] data_q,
  output logic [DW-1:0] mask_q
);
  localparam logic [XW-1:0] XMAX      = XW'(NCOL - 1);
  localparam logic [YW-1:0] ICON_BANK = YW'(NBANK - 1);
  localparam logic [DW-1:0] ICON_MASK = DW'(1);

  logic [DW-1:0] din_rev;
  logic [DW-1:0] data_d;
  logic [XW-1:0] col_d;
  logic [DW-1:0] mask_d;

  for (genvar k = 0; k < DW; k++) begin : g_rev
    assign din_rev[k] = din[DW-1-k];
  end

  always_comb begin
    col_d  = mirror ? (XMAX - x) : x;
    data_d = lsb_top ? din : din_rev;
    mask_d = (y == ICON_BANK) ? ICON_MASK : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b0;
    end else begin
      we_q <= wr_stb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      col_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else if (wr_stb) begin
      bank_q <= y;
      col_q  <= col_d;
      data_q <= data_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/dram_wr_addr_gen.sv
module dram_wr_addr_gen #(
  parameter int NCOL  = 128,
  parameter int NBANK = 9,
  parameter int DW    = 8,
  localparam int XW   = $clog2(NCOL),
  localparam int YW   = $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_vert,
  input  logic          cfg_mirror,
  input  logic          cfg_lsb_top,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          ld_x,
  input  logic [XW-1:0] ld_x_val,
  input  logic          ld_y,
  input  logic [YW-1:0] ld_y_val,
  output logic          ram_we,
  output logic [YW-1:0] ram_bank,
  output logic [XW-1:0] ram_col,
  output logic [DW-1:0] ram_data,
  output logic [DW-1:0] ram_mask,
  output logic [XW-1:0] ptr_x,
  output logic [YW-1:0] ptr_y
);
  import wag_pkg::*;

  walk_order_e order;
  assign order = cfg_vert ? ORDER_BANK_FIRST : ORDER_COL_FIRST;

  wag_ptr #(.NCOL(NCOL), .NBANK(NBANK), .XW(XW), .YW(YW)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (wr_stb),
    .order   (order),
    .ldx     (ld_x),
    .ldx_val (ld_x_val),
    .ldy     (ld_y),
    .ldy_val (ld_y_val),
    .x_q     (ptr_x),
    .y_q     (ptr_y)
  );

  wag_map #(.NCOL(NCOL), .NBANK(NBANK), .DW(DW), .XW(XW), .YW(YW)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .x       (ptr_x),
    .y       (ptr_y),
    .mirror  (cfg_mirror),
    .lsb_top (cfg_lsb_top),
    .din     (wr_data),
    .we_q    (ram_we),
    .bank_q  (ram_bank),
    .col_q   (ram_col),
    .data_q  (ram_data),
    .mask_q  (ram_mask)
  );
endmodule

// File: rtl/dram_wr_addr_gen_chk.sv
module dram_wr_addr_gen_chk #(
  parameter int NCOL  = 128,
  parameter int NBANK = 9,
  parameter int DW    = 8,
  parameter int XW    = 7,
  parameter int YW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_vert,
  input logic          wr_stb,
  input logic          ld_x,
  input logic          ld_y,
  input logic [YW-1:0] ld_y_val,
  input logic          ram_we,
  input logic [YW-1:0] ram_bank,
  input logic [DW-1:0] ram_mask,
  input logic [XW-1:0] ptr_x,
  input logic [YW-1:0] ptr_y
);
  localparam logic [XW-1:0] XMAX = XW'(NCOL - 1);
  localparam logic [YW-1:0] YMAX = YW'(NBANK - 1);

  a_r9_bank_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_y <= YMAX);

  a_r2_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !ld_x && !ld_y && !cfg_vert && ptr_x != XMAX)
      |=> (ptr_x == $past(ptr_x) + 1'b1) && $stable(ptr_y));

  a_r3_bank_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !ld_x && !ld_y && cfg_vert && ptr_y != YMAX)
      |=> (ptr_y == $past(ptr_y) + 1'b1) && $stable(ptr_x));

  a_r4_corner_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !ld_x && !ld_y && ptr_x == XMAX && ptr_y == YMAX)
      |=> (ptr_x == '0) && (ptr_y == '0));

  a_r5_we_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> ram_we && (ram_bank == $past(ptr_y)));

  a_r5_no_spurious_we: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> !ram_we);

  a_r8_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_bank != YMAX) |-> (ram_mask == '1));

  a_r9_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_y && ld_y_val > YMAX) |=> (ptr_y == YMAX));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !ld_x && !ld_y) |=> $stable(ptr_x) && $stable(ptr_y));
endmodule

bind dram_wr_addr_gen dram_wr_addr_gen_chk #(
  .NCOL(NCOL), .NBANK(NBANK), .DW(DW), .XW(XW), .YW(YW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_vert (cfg_vert),
  .wr_stb   (wr_stb),
  .ld_x     (ld_x),
  .ld_y     (ld_y),
  .ld_y_val (ld_y_val),
  .ram_we   (ram_we),
  .ram_bank (ram_bank),
  .ram_mask (ram_mask),
  .ptr_x    (ptr_x),
  .ptr_y    (ptr_y)
);

// File: tb/sim_dram_wr_addr_gen.sv
module sim_dram_wr_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int MAXCYC     = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_vert, cfg_mirror, cfg_lsb_top;
  logic       wr_stb, ld_x, ld_y;
  logic [7:0] wr_data;
  logic [6:0] ld_x_val;
  logic [3:0] ld_y_val;
  logic       ram_we;
  logic [3:0] ram_bank;
  logic [6:0] ram_col;
  logic [7:0] ram_data, ram_mask;
  logic [6:0] ptr_x;
  logic [3:0] ptr_y;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [6:0] mx;
  logic [3:0] my;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_wr_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_vert(cfg_vert), .cfg_mirror(cfg_mirror),
    .cfg_lsb_top(cfg_lsb_top), .wr_stb(wr_stb), .wr_data(wr_data),
    .ld_x(ld_x), .ld_x_val(ld_x_val), .ld_y(ld_y), .ld_y_val(ld_y_val),
    .ram_we(ram_we), .ram_bank(ram_bank), .ram_col(ram_col),
    .ram_data(ram_data), .ram_mask(ram_mask), .ptr_x(ptr_x), .ptr_y(ptr_y)
  );

  function automatic logic [7:0] rev8(input logic [7:0] d);
    for (int k = 0; k < 8; k++) rev8[k] = d[7-k];
  endfunction

  function automatic logic [7:0] exp_data(input logic [7:0] d, input logic lsb);
    return lsb ? d : rev8(d);
  endfunction

  function automatic logic [6:0] exp_col(input logic [6:0] x, input logic mir);
    return mir ? 7'(127 - x) : x;
  endfunction

  function automatic logic [7:0] exp_mask(input logic [3:0] y);
    return (y == 4'd8) ? 8'h01 : 8'hFF;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, inputs settle, check at the following negedge
  task automatic op(input logic w, input logic [7:0] d,
                    input logic lx, input logic [6:0] vx,
                    input logic ly, input logic [3:0] vy);
    logic [6:0] ox;
    logic [3:0] oy;
    ox = mx; oy = my;
    wr_stb = w; wr_data = d; ld_x = lx; ld_x_val = vx; ld_y = ly; ld_y_val = vy;
    if (w) begin
      if (!cfg_vert) begin
        if (mx == 7'd127) begin mx = 0; my = (my == 4'd8) ? 4'd0 : my + 1'b1; end
        else mx = mx + 1'b1;
      end else begin
        if (my == 4'd8) begin my = 0; mx = mx + 1'b1; end
        else my = my + 1'b1;
      end
    end
    if (lx) mx = vx;
    if (ly) my = (vy > 4'd8) ? 4'd8 : vy;
    @(negedge clk);
    wr_stb = 0; ld_x = 0; ld_y = 0;
    if (w) begin
      chk("R5 we", int'(ram_we), 1);
      chk("R5 bank", int'(ram_bank), int'(oy));
      chk("R6 col", int'(ram_col), int'(exp_col(ox, cfg_mirror)));
      chk("R7 data", int'(ram_data), int'(exp_data(d, cfg_lsb_top)));
      chk("R8 mask", int'(ram_mask), int'(exp_mask(oy)));
    end else begin
      chk("R5 idle we", int'(ram_we), 0);
    end
    if (lx || ly) begin
      chk("R9 load x", int'(ptr_x), int'(mx));
      chk("R9 load y", int'(ptr_y), int'(my));
    end else if (w && !cfg_vert) begin
      chk("R2 x", int'(ptr_x), int'(mx));
      chk("R2 y", int'(ptr_y), int'(my));
    end else if (w) begin
      chk("R3 x", int'(ptr_x), int'(mx));
      chk("R3 y", int'(ptr_y), int'(my));
    end else begin
      chk("R10 x", int'(ptr_x), int'(mx));
      chk("R10 y", int'(ptr_y), int'(my));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAXCYC && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, MAXCYC);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; cfg_vert = 0; cfg_mirror = 0; cfg_lsb_top = 0;
    wr_stb = 0; wr_data = 0; ld_x = 0; ld_x_val = 0; ld_y = 0; ld_y_val = 0;
    mx = 0; my = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset x", int'(ptr_x), 0);
    chk("R1 reset y", int'(ptr_y), 0);
    chk("R1 reset we", int'(ram_we), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release x", int'(ptr_x), 0);
    chk("R1 after release we", int'(ram_we), 0);

    // R2 and R4: full column-first sweep, ends back at origin
    for (int i = 0; i < 128*9; i++) op(1, 8'(i), 0, 0, 0, 0);
    chk("R4 col-first origin x", int'(ptr_x), 0);
    chk("R4 col-first origin y", int'(ptr_y), 0);

    // R3 and R4: full bank-first sweep with mirror and lsb-top
    cfg_vert = 1; cfg_mirror = 1; cfg_lsb_top = 1;
    for (int i = 0; i < 128*9; i++) op(1, 8'(i * 7), 0, 0, 0, 0);
    chk("R4 bank-first origin x", int'(ptr_x), 0);
    chk("R4 bank-first origin y", int'(ptr_y), 0);

    // R9: clamp and load priority over a simultaneous write
    op(0, 0, 0, 0, 1, 4'd15);
    chk("R9 clamp", int'(ptr_y), 8);
    op(1, 8'hA5, 1, 7'd127, 0, 0);
    op(0, 0, 0, 0, 0, 0);
    // R8: icon bank write with only one bit enabled
    cfg_vert = 0; cfg_lsb_top = 0;
    op(0, 0, 1, 7'd127, 1, 4'd8);
    op(1, 8'h80, 0, 0, 0, 0);
    chk("R4 directed corner x", int'(ptr_x), 0);
    chk("R4 directed corner y", int'(ptr_y), 0);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = int'($urandom_range(0, 15));
      if (r == 0) begin
        cfg_vert = 1'($urandom); cfg_mirror = 1'($urandom); cfg_lsb_top = 1'($urandom);
      end
      op(r > 3, 8'($urandom), r == 2 || r == 15, 7'($urandom),
         r == 3 || r == 14, 4'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule